// File: doc/BRIEF.md
# General Purpose I/O Port with Edge Interrupts

This block is an eight-bit pin controller with a small register file. It sits between a CPU bus and a row of pads. Each bit can be an input or an output. Each bit can also be taken over by a neighbouring peripheral, for example a PWM generator or a capture/compare timer. The block drives the pad output enable, the pad output value and the pad pull controls. It also samples the pad levels through a synchronizer.

One register bit per pin selects both the pull direction and the edge that counts for that pin's interrupt. When a selected edge arrives, the pin's sticky flag is set. Software clears a flag by writing a one to it. A single registered interrupt line stays high while any flag whose enable bit is set remains set. Two read paths report the pins. The data read gives the written value for outputs and the sampled level for inputs. The pin-level read always gives the sampled level, including on pins a peripheral is driving.

Register map (reg_addr): 0 data latch, 1 direction, 2 pin level (read only), 3 pull enable, 4 polarity, 5 interrupt enable, 6 interrupt flags (write one to clear), 7 unused.

Top module: `gpio_port`

## Requirements
- R1: Synchronous active-high reset `rst` clears data latch, direction, pull enable, polarity, interrupt enable, flags and `irq`. After reset every pin is an input, no pull is applied, and every register reads 0 while `pad_in` is 0.
- R2: For each bit i, a direction bit of 1 sets `pad_oe[i]`. With no peripheral override, `pad_out[i]` equals data latch bit i. A direction bit of 0 leaves `pad_oe[i]` low.
- R3: `pad_pull_en` equals the pull-enable register. `pad_pull_dn[i]` is 1 only when pull enable bit i and polarity bit i are both 1. Polarity 0 with pull enabled selects a pull-up.
- R4: When `alt_en[i]` is 1, `pad_oe[i]` is 1 and `pad_out[i]` equals `alt_val[i]`. The data latch keeps its written value, and that value is seen again once `alt_en[i]` returns to 0.
- R5: Reading address 2 returns the level of `pad_in` as it was two clock edges earlier, whatever the direction or override. Writes to address 2 change nothing.
- R6: Reading address 0 returns data latch bit i where direction bit i is 1, and the two-edge-delayed pin level where direction bit i is 0.
- R7: With polarity bit 0, a high-to-low change of the synchronized level sets flag bit i. With polarity bit 1, a low-to-high change sets it. This holds for output pins as well. The flag becomes visible at address 6 three clock edges after `pad_in` changes.
- R8: Writing 1 to a bit at address 6 clears that flag, and writing 0 leaves it. If an edge sets the flag in the same cycle as the clear, the flag stays set.
- R9: `irq` is a register. It is high in the cycle after any bit of (flags AND interrupt enable) is set, and low in the cycle after none is. Flags on pins whose enable bit is 0 never raise `irq`.
- R10: Writes to address 7 change nothing, and reads from address 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Combinational read data for reg_addr |
| alt_en | input | W | Per-bit peripheral override enable |
| alt_val | input | W | Per-bit peripheral output value |
| pad_in | input | W | Asynchronous pad input levels |
| pad_oe | output | W | Pad output enable |
| pad_out | output | W | Pad output value |
| pad_pull_en | output | W | Pad pull resistor enable |
| pad_pull_dn | output | W | Pad pull direction, 1 = pull-down |
| irq | output | 1 | Registered combined interrupt request |

## Verification
A flag clear written by software and a new edge from the synchronizer can land on the same clock edge. The bench provokes this by toggling one pin and then sweeping the clear write across four offsets from that toggle. One of those offsets hits the exact edge on which the detector fires. A behavioural model judges every cycle: the flag must survive a coincident clear, and `irq` must follow one cycle later. A long stretch of random register traffic and random pin activity then gives the same collision further chances, including on pins that are outputs or under peripheral override.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
   localparam int unsigned ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      RA_DATA  = 3'd0,
      RA_DIR   = 3'd1,
      RA_PIN   = 3'd2,
      RA_PULL  = 3'd3,
      RA_POL   = 3'd4,
      RA_IEN   = 3'd5,
      RA_FLAG  = 3'd6,
      RA_SPARE = 3'd7
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] async_in,
   output logic [W-1:0] sync_out
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) stg[g] <= '0;
            else     stg[g] <= async_in;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) stg[g] <= '0;
            else     stg[g] <= stg[g-1];
         end
      end
   end

   assign sync_out = stg[STAGES-1];
endmodule

// File: rtl/gpio_edge_flags.sv
module gpio_edge_flags #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] sync_in,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] clr_mask,
   output logic [W-1:0] flag
);
   logic [W-1:0] prev;
   logic [W-1:0] hit;

   for (genvar i = 0; i < W; i++) begin : g_det
      always_comb begin
         if (pol[i]) hit[i] = sync_in[i] & ~prev[i];
         else        hit[i] = ~sync_in[i] & prev[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev <= '0;
         flag <= '0;
      end else begin
         prev <= sync_in;
         flag <= (flag & ~clr_mask) | hit;
      end
   end

   // R8: a clear with no coinciding edge empties the flag
   assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((flag & $past(clr_mask & ~hit)) == '0));

   // R8: an edge in the clear cycle still leaves the flag set
   assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((flag & $past(hit)) == $past(hit)));

   for (genvar i = 0; i < W; i++) begin : g_chk
      assert_fall_R7: assert property (@(posedge clk) disable iff (rst)
         ($fell(sync_in[i]) && !pol[i]) |=> flag[i]);
      assert_rise_R7: assert property (@(posedge clk) disable iff (rst)
         ($rose(sync_in[i]) && pol[i]) |=> flag[i]);
   end
endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] dir,
   input  logic [W-1:0] latch,
   input  logic [W-1:0] pull_en,
   input  logic [W-1:0] pol,
   input  logic [W-1:0] alt_en,
   input  logic [W-1:0] alt_val,
   output logic [W-1:0] pad_oe,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_pull_en,
   output logic [W-1:0] pad_pull_dn
);
   for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
         pad_oe[i]      = dir[i] | alt_en[i];
         pad_out[i]     = alt_en[i] ? alt_val[i] : latch[i];
         pad_pull_en[i] = pull_en[i];
         pad_pull_dn[i] = pull_en[i] & pol[i];
      end
   end

   assert_alt_drive_R4: assert property (@(posedge clk) disable iff (rst)
      ((alt_en & ~pad_oe) == '0) && (((pad_out ^ alt_val) & alt_en) == '0));

   assert_pull_dir_R3: assert property (@(posedge clk) disable iff (rst)
      (pad_pull_dn & ~pad_pull_en) == '0);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned W           = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [W-1:0]      reg_wdata,
   output logic [W-1:0]      reg_rdata,
   input  logic [W-1:0]      alt_en,
   input  logic [W-1:0]      alt_val,
   input  logic [W-1:0]      pad_in,
   output logic [W-1:0]      pad_oe,
   output logic [W-1:0]      pad_out,
   output logic [W-1:0]      pad_pull_en,
   output logic [W-1:0]      pad_pull_dn,
   output logic              irq
);
   if (W < 1) begin : g_bad_width
      $error("gpio_port: W must be at least 1");
   end

   logic [W-1:0] latch_q, dir_q, pull_q, pol_q, ien_q;
   logic [W-1:0] pin_s, flag_q, clr_mask;
   gpio_reg_e    sel;

   assign sel      = gpio_reg_e'(reg_addr);
   assign clr_mask = (reg_wr && sel == RA_FLAG) ? reg_wdata : '0;

   always_ff @(posedge clk) begin
      if (rst) begin
         latch_q <= '0;
         dir_q   <= '0;
         pull_q  <= '0;
         pol_q   <= '0;
         ien_q   <= '0;
         irq     <= 1'b0;
      end else begin
         irq <= |(flag_q & ien_q);
         if (reg_wr) begin
            case (sel)
               RA_DATA: latch_q <= reg_wdata;
               RA_DIR:  dir_q   <= reg_wdata;
               RA_PULL: pull_q  <= reg_wdata;
               RA_POL:  pol_q   <= reg_wdata;
               RA_IEN:  ien_q   <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (sel)
         RA_DATA: reg_rdata = (dir_q & latch_q) | (~dir_q & pin_s);
         RA_DIR:  reg_rdata = dir_q;
         RA_PIN:  reg_rdata = pin_s;
         RA_PULL: reg_rdata = pull_q;
         RA_POL:  reg_rdata = pol_q;
         RA_IEN:  reg_rdata = ien_q;
         RA_FLAG: reg_rdata = flag_q;
         default: reg_rdata = '0;
      endcase
   end

   gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .async_in(pad_in), .sync_out(pin_s)
   );

   gpio_edge_flags #(.W(W)) u_edge (
      .clk(clk), .rst(rst), .sync_in(pin_s), .pol(pol_q),
      .clr_mask(clr_mask), .flag(flag_q)
   );

   gpio_pad_mux #(.W(W)) u_pad (
      .clk(clk), .rst(rst), .dir(dir_q), .latch(latch_q),
      .pull_en(pull_q), .pol(pol_q), .alt_en(alt_en), .alt_val(alt_val),
      .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_pull_en(pad_pull_en), .pad_pull_dn(pad_pull_dn)
   );

   // R9: with no enabled flag for two cycles the request is low
   assert_irq_low_R9: assert property (@(posedge clk) disable iff (rst)
      (((flag_q & ien_q) == '0) && $past((flag_q & ien_q) == '0)) |-> !irq);

   // R9: an enabled flag held for a cycle gives a high request
   assert_irq_high_R9: assert property (@(posedge clk) disable iff (rst)
      ($past((flag_q & ien_q) != '0)) |-> irq);

   // R1: first cycle out of reset shows inputs, no pulls, no request
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (pad_oe == alt_en && pad_pull_en == '0 && !irq));
endmodule

// File: tb/sim_gpio_port.sv
`timescale 1ns/100ps
module sim_gpio_port;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         reg_wr = 1'b0;
   logic [2:0]   reg_addr = '0;
   logic [W-1:0] reg_wdata = '0;
   logic [W-1:0] reg_rdata;
   logic [W-1:0] alt_en = '0, alt_val = '0, pad_in = '0;
   logic [W-1:0] pad_oe, pad_out, pad_pull_en, pad_pull_dn;
   logic         irq;

   always #2.5 clk = ~clk;

   gpio_port #(.W(W), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .alt_en(alt_en),
      .alt_val(alt_val), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
      .pad_pull_en(pad_pull_en), .pad_pull_dn(pad_pull_dn), .irq(irq)
   );

   int total = 0, failed = 0;
   bit done = 1'b0;

   // behavioural reference state
   logic [W-1:0] m_lat, m_dir, m_pe, m_pol, m_ien, m_flag;
   logic         m_irq;
   logic [W-1:0] m_hist[$];

   task automatic model_reset();
      m_lat = '0; m_dir = '0; m_pe = '0; m_pol = '0; m_ien = '0; m_flag = '0;
      m_irq = 1'b0;
      m_hist = '{8'h00, 8'h00, 8'h00};
   endtask

   task automatic model_edge();
      logic [W-1:0] s, p, e, clr;
      s = m_hist[1];
      p = m_hist[2];
      e = (m_pol & s & ~p) | (~m_pol & ~s & p);
      clr = (reg_wr && reg_addr == 3'd6) ? reg_wdata : '0;
      m_irq = ((m_flag & m_ien) != 0);
      m_flag = (m_flag & ~clr) | e;
      if (reg_wr) begin
         case (reg_addr)
            3'd0: m_lat = reg_wdata;
            3'd1: m_dir = reg_wdata;
            3'd3: m_pe  = reg_wdata;
            3'd4: m_pol = reg_wdata;
            3'd5: m_ien = reg_wdata;
            default: ;
         endcase
      end
      m_hist.push_front(pad_in);
      void'(m_hist.pop_back());
   endtask

   function automatic logic [W-1:0] exp_read(logic [2:0] a);
      case (a)
         3'd0: return (m_dir & m_lat) | (~m_dir & m_hist[1]);
         3'd1: return m_dir;
         3'd2: return m_hist[1];
         3'd3: return m_pe;
         3'd4: return m_pol;
         3'd5: return m_ien;
         3'd6: return m_flag;
         default: return '0;
      endcase
   endfunction

   function automatic string addr_tag(logic [2:0] a);
      case (a)
         3'd0: return "R6";
         3'd1: return "R2";
         3'd2: return "R5";
         3'd3, 3'd4: return "R3";
         3'd5: return "R9";
         3'd6: return "R8";
         default: return "R10";
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         failed++;
         $display("FAIL %s %s: actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   // one cycle: drive, compare in the low phase, clock, update model
   task automatic step(logic w, logic [2:0] a, logic [W-1:0] d, string tag);
      string t;
      reg_wr = w; reg_addr = a; reg_wdata = d;
      #1;
      t = (tag == "") ? addr_tag(a) : tag;
      chk(t, "rdata", reg_rdata, exp_read(a));
      chk("R2", "pad_oe", pad_oe, m_dir | alt_en);
      chk("R4", "pad_out", pad_out, (alt_en & alt_val) | (~alt_en & m_lat));
      chk("R3", "pull_en", pad_pull_en, m_pe);
      chk("R3", "pull_dn", pad_pull_dn, m_pe & m_pol);
      chk("R9", "irq", {7'd0, irq}, {7'd0, m_irq});
      @(posedge clk);
      model_edge();
      @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, logic [W-1:0] d); step(1'b1, a, d, ""); endtask
   task automatic rd(logic [2:0] a, string tag);       step(1'b0, a, '0, tag); endtask
   task automatic idle(int n);
      for (int k = 0; k < n; k++) step(1'b0, 3'd6, '0, "");
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++; failed++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("%0d/%0d checks passed", total - failed, total);
         $finish;
      end
   end

   initial begin : stim
      rst = 1'b1;
      repeat (3) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst = 1'b0;

      // R1: reset values on every address
      for (int a = 0; a < 8; a++) rd(3'(a), "R1");

      // R2 / R6: mixed direction, pins differ from latch
      pad_in = 8'h0C;
      wr(3'd1, 8'hF0);
      wr(3'd0, 8'hA5);
      idle(2);
      rd(3'd0, "R6");
      rd(3'd2, "R5");

      // R3: pull enable and polarity combinations
      wr(3'd3, 8'h3C);
      wr(3'd4, 8'h0F);
      rd(3'd3, "R3");
      wr(3'd4, 8'h00);
      wr(3'd3, 8'h00);

      // R4: peripheral override, latch survives
      alt_en = 8'h81; alt_val = 8'h01;
      wr(3'd0, 8'h5A);
      rd(3'd0, "R4");
      alt_en = 8'h00;
      rd(3'd0, "R4");

      // R5 / R10: pin register tracks pads, read-only; spare address inert
      for (int k = 0; k < 6; k++) begin
         pad_in = 8'(k * 37 + 3);
         rd(3'd2, "R5");
      end
      wr(3'd2, 8'hFF);
      wr(3'd7, 8'hFF);
      rd(3'd7, "R10");
      for (int a = 0; a < 7; a++) rd(3'(a), "R10");

      // R7: falling edge on an output pin (bit 7) and an input pin (bit 1)
      pad_in = 8'h82; idle(4);
      wr(3'd6, 8'hFF);
      pad_in = 8'h00;
      for (int k = 0; k < 4; k++) rd(3'd6, "R7");
      // R7: rising edge with polarity 1 on bit 2; falling ignored there
      wr(3'd6, 8'hFF);
      wr(3'd4, 8'h04);
      pad_in = 8'h04;
      for (int k = 0; k < 4; k++) rd(3'd6, "R7");
      pad_in = 8'h00;
      for (int k = 0; k < 4; k++) rd(3'd6, "R7");
      wr(3'd4, 8'h00);

      // R8: clear swept across the detection edge
      for (int off = 0; off < 4; off++) begin
         pad_in = 8'h08; idle(4);
         wr(3'd6, 8'hFF);
         pad_in = 8'h00;
         idle(off);
         wr(3'd6, 8'h08);
         rd(3'd6, "R8");
         rd(3'd6, "R8");
         wr(3'd6, 8'h00);
         rd(3'd6, "R8");
      end
      wr(3'd6, 8'hFF);

      // R9: flag without enable, then enable, then clear
      pad_in = 8'h10; idle(4);
      wr(3'd6, 8'hFF);
      pad_in = 8'h00; idle(5);
      wr(3'd5, 8'h10);
      idle(3);
      wr(3'd6, 8'h10);
      idle(3);

      // mixed random traffic
      for (int k = 0; k < 600; k++) begin
         if ($urandom_range(0, 3) == 0) pad_in = 8'($urandom);
         if ($urandom_range(0, 7) == 0) begin
            alt_en = 8'($urandom); alt_val = 8'($urandom);
         end
         step(($urandom_range(0, 2) == 0), 3'($urandom_range(0, 7)), 8'($urandom), "");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
   end
endmodule